// File: doc/BRIEF.md
# Three-Phase Gate Drive Interlock

This block sits between a motor-control processor and the gate drivers of a three-phase half-bridge. Each phase takes one high-side and one low-side command. The block turns them into registered gate-enable outputs and applies three protections on the way. It never lets both switches of a leg conduct together. It holds a programmable blanking interval before any switch turns on. After reset or after the enables drop, it refuses a high-side turn-on until that phase's low side has been on long enough to recharge the bootstrap capacitor.

The command inputs pass through two-flop synchronisers before the interlock logic sees them. Two enable inputs and the reset force every gate output off combinationally, with no clock edge needed. Configuration arrives as plain register inputs: a dead-time count and two override bits. One override removes the blanking interval. The other allows both switches of a leg to be on at once. While the enables are low the configuration inputs keep acting, and each phase's sticky fault flag holds its value.

Top module: `tri_gate_guard`

## Requirements
- R1: If `en_a` or `en_b` is low, all six gate outputs are 0 in the same cycle, without waiting for a clock edge. Every phase's precharged flag and internal drive state is cleared at that moment.
- R2: While `rst_n` is low, all gate outputs and all fault flags are 0.
- R3: `hs_cmd_n[i]` is active low and `ls_cmd[i]` is active high. With `hs_cmd_n=3'b111` and `ls_cmd=3'b000`, no gate output turns on.
- R4: A command change set up before clock edge k takes effect on the outputs right after edge k+2: two synchroniser stages plus the output register.
- R5: When the override is clear and a phase has both commands active, both outputs of that phase go off, and `fault[i]` is set at the edge where the conflicting command reaches the interlock.
- R6: With `cfg_xc_bypass=1`, each output of a phase follows its own command: the low side directly, the high side subject only to R9. Both may be on together, and no fault is raised.
- R7: When the dead-time bypass is clear, a switch turns on only after the leg has been off for `cfg_dead+1` clock edges, counted from the edge that turned the other switch off. A value of 0 therefore leaves exactly one off cycle.
- R8: With `cfg_dt_bypass=1`, the blanking count is ignored. A changeover then takes exactly one off cycle.
- R9: After reset or after the enables rise, `gate_hs[i]` stays off until `gate_ls[i]` has been on for at least 2 consecutive clock edges.
- R10: A phase that had been precharged before the enables dropped must be precharged again before its high side can turn on.
- R11: `fault[i]` is sticky. Only reset clears it, and dropping the enables leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_a | input | 1 | Gate enable, first input (active high) |
| en_b | input | 1 | Gate enable, second input (active high) |
| hs_cmd_n | input | 3 | High-side command per phase, active low |
| ls_cmd | input | 3 | Low-side command per phase, active high |
| cfg_dead | input | 6 | Dead-time count in clock cycles |
| cfg_dt_bypass | input | 1 | 1 = skip the dead-time count |
| cfg_xc_bypass | input | 1 | 1 = allow both switches of a leg on |
| gate_hs | output | 3 | High-side gate enable per phase |
| gate_ls | output | 3 | Low-side gate enable per phase |
| fault | output | 3 | Sticky cross-conduction fault per phase |

## Verification
The assertions assume three things about the inputs. The configuration inputs change only between clock edges. A lapse of the enables lasts across at least one edge. When the cross-conduction override is cleared, the shoot-through check allows one edge for the design to let go of a leg that the override had left fully on. The stimulus keeps to these assumptions because it drives every input, enables and configuration included, only at falling clock edges. It also leaves the override bits and the enables at each value for many cycles, so both directions of every toggle are covered without ever presenting a change in the middle of a cycle.

// File: rtl/tgd_pkg.sv
package tgd_pkg;
  localparam int unsigned NPH_DEF  = 3;
  localparam int unsigned DT_W_DEF = 6;

  // decision taken for one leg at an edge
  typedef enum logic [2:0] {
    ACT_KEEP,
    ACT_OFF,
    ACT_ON_LS,
    ACT_ON_HS,
    ACT_WAIT,
    ACT_FREE
  } leg_act_e;
endpackage

// File: rtl/tgd_sync.sv
module tgd_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      stg1_q <= RST_VAL;
      stg2_q <= RST_VAL;
    end else begin
      stg1_q <= d;
      stg2_q <= stg1_q;
    end
  end

  assign q = stg2_q;
endmodule

// File: rtl/tgd_phase.sv
module tgd_phase
  import tgd_pkg::*;
#(
  parameter int unsigned DT_W = DT_W_DEF
) (
  input  logic            clk,
  input  logic            arm_n,
  input  logic            core_rst_n,
  input  logic            en_s,
  input  logic            hs_req,
  input  logic            ls_req,
  input  logic [DT_W-1:0] dead,
  input  logic            dt_byp,
  input  logic            xc_byp,
  output logic            hs_on,
  output logic            ls_on,
  output logic            xc_fault
);
  localparam logic [DT_W-1:0] CNT_ONE = {{(DT_W-1){1'b0}}, 1'b1};
  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

  logic            hs_q, hs_d;
  logic            ls_q, ls_d;
  logic            pre_q, pre_d;
  logic            run_q;
  logic [DT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic            want_hs, want_ls, gap_ok;
  logic            flt_q, flt_set;
  leg_act_e        act;

  assign want_hs = hs_req & ~ls_req;
  assign want_ls = ls_req & ~hs_req;
  assign gap_ok  = dt_byp | (cnt_q >= dead);
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;

  // choose the action for this edge
  always_comb begin
    act = ACT_KEEP;
    if (xc_byp) begin
      act = ACT_FREE;
    end else if (hs_q && ls_q) begin
      act = ACT_OFF;
    end else if (hs_q) begin
      if (!want_hs) act = ACT_OFF;
    end else if (ls_q) begin
      if (!want_ls) act = ACT_OFF;
    end else if (gap_ok && want_ls) begin
      act = ACT_ON_LS;
    end else if (gap_ok && want_hs && pre_q) begin
      act = ACT_ON_HS;
    end else begin
      act = ACT_WAIT;
    end
  end

  // next state from the action
  always_comb begin
    hs_d  = hs_q;
    ls_d  = ls_q;
    cnt_d = cnt_q;
    pre_d = pre_q | (ls_q & run_q);
    unique case (act)
      ACT_KEEP: ;
      ACT_OFF: begin
        hs_d  = 1'b0;
        ls_d  = 1'b0;
        cnt_d = '0;
      end
      ACT_ON_LS: ls_d = 1'b1;
      ACT_ON_HS: hs_d = 1'b1;
      ACT_WAIT:  cnt_d = cnt_inc;
      ACT_FREE: begin
        hs_d  = hs_req & pre_q;
        ls_d  = ls_req;
        cnt_d = (hs_d | ls_d) ? '0 : cnt_inc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge arm_n) begin
    if (!arm_n) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      pre_q <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      hs_q  <= hs_d;
      ls_q  <= ls_d;
      pre_q <= pre_d;
      run_q <= ls_q;
      cnt_q <= cnt_d;
    end
  end

  // sticky fault, cleared only by reset
  assign flt_set = en_s & hs_req & ls_req & ~xc_byp;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      flt_q <= 1'b0;
    end else if (flt_set) begin
      flt_q <= 1'b1;
    end
  end

  assign hs_on    = hs_q;
  assign ls_on    = ls_q;
  assign xc_fault = flt_q;
endmodule

// File: rtl/tri_gate_guard.sv
module tri_gate_guard
  import tgd_pkg::*;
#(
  parameter int unsigned NPH  = NPH_DEF,
  parameter int unsigned DT_W = DT_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_a,
  input  logic            en_b,
  input  logic [NPH-1:0]  hs_cmd_n,
  input  logic [NPH-1:0]  ls_cmd,
  input  logic [DT_W-1:0] cfg_dead,
  input  logic            cfg_dt_bypass,
  input  logic            cfg_xc_bypass,
  output logic [NPH-1:0]  gate_hs,
  output logic [NPH-1:0]  gate_ls,
  output logic [NPH-1:0]  fault
);
  logic           en_all;
  logic           rst_i;
  logic           en_s;
  logic           arm_n;
  logic           en_clr_n;
  logic           pass;
  logic [NPH-1:0] hs_s_n, ls_s;
  logic [NPH-1:0] hs_q, ls_q;

  assign en_all   = en_a & en_b;
  assign en_clr_n = rst_i & en_all;
  assign arm_n    = rst_i & en_s;
  assign pass     = en_all & rst_n;

  tgd_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .clr_n(rst_n), .d(1'b1), .q(rst_i)
  );

  tgd_sync #(.W(1), .RST_VAL(1'b0)) u_en_sync (
    .clk(clk), .clr_n(en_clr_n), .d(1'b1), .q(en_s)
  );

  tgd_sync #(.W(NPH), .RST_VAL({NPH{1'b1}})) u_hs_sync (
    .clk(clk), .clr_n(rst_i), .d(hs_cmd_n), .q(hs_s_n)
  );

  tgd_sync #(.W(NPH), .RST_VAL({NPH{1'b0}})) u_ls_sync (
    .clk(clk), .clr_n(rst_i), .d(ls_cmd), .q(ls_s)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_leg
    tgd_phase #(.DT_W(DT_W)) u_leg (
      .clk       (clk),
      .arm_n     (arm_n),
      .core_rst_n(rst_i),
      .en_s      (en_s),
      .hs_req    (~hs_s_n[g]),
      .ls_req    (ls_s[g]),
      .dead      (cfg_dead),
      .dt_byp    (cfg_dt_bypass),
      .xc_byp    (cfg_xc_bypass),
      .hs_on     (hs_q[g]),
      .ls_on     (ls_q[g]),
      .xc_fault  (fault[g])
    );
  end

  // combinational forced-off path
  assign gate_hs = hs_q & {NPH{pass}};
  assign gate_ls = ls_q & {NPH{pass}};
endmodule

// File: rtl/tri_gate_guard_chk.sv
module tri_gate_guard_chk #(
  parameter int unsigned NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_a,
  input logic           en_b,
  input logic           cfg_xc_bypass,
  input logic [NPH-1:0] gate_hs,
  input logic [NPH-1:0] gate_ls,
  input logic [NPH-1:0] fault
);
  logic [NPH-1:0] ls_prev_q;
  logic [NPH-1:0] charged_q;

  // port-level record of a two-edge low-side pulse since enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_prev_q <= '0;
      charged_q <= '0;
    end else if (!(en_a && en_b)) begin
      ls_prev_q <= '0;
      charged_q <= '0;
    end else begin
      ls_prev_q <= gate_ls;
      charged_q <= charged_q | (gate_ls & ls_prev_q);
    end
  end

  AST_EN_FORCE_OFF: assert property (@(posedge clk)
    !(en_a && en_b) |-> (gate_hs == '0 && gate_ls == '0)); // R1

  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_n |-> (gate_hs == '0 && gate_ls == '0 && fault == '0)); // R2

  for (genvar p = 0; p < NPH; p++) begin : g_chk
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_xc_bypass && !$past(cfg_xc_bypass)) |-> !(gate_hs[p] && gate_ls[p])); // R5

    AST_BOOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hs[p]) |-> charged_q[p]); // R9

    AST_GAP_BEFORE_HS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_hs[p]) && !cfg_xc_bypass && !$past(cfg_xc_bypass)) |-> !$past(gate_ls[p])); // R7

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fault[p]) |-> fault[p]); // R11
  end
endmodule

bind tri_gate_guard tri_gate_guard_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b),
  .cfg_xc_bypass(cfg_xc_bypass), .gate_hs(gate_hs), .gate_ls(gate_ls),
  .fault(fault)
);

// File: tb/tri_gate_guard_bench.sv
module tri_gate_guard_bench;
  logic       clk;
  logic       rst_n;
  logic       en_a, en_b;
  logic [2:0] hs_cmd_n, ls_cmd;
  logic [5:0] cfg_dead;
  logic       cfg_dt_bypass, cfg_xc_bypass;
  logic [2:0] gate_hs, gate_ls, fault;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  tri_gate_guard u_tri_gate_guard (
    .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b),
    .hs_cmd_n(hs_cmd_n), .ls_cmd(ls_cmd), .cfg_dead(cfg_dead),
    .cfg_dt_bypass(cfg_dt_bypass), .cfg_xc_bypass(cfg_xc_bypass),
    .gate_hs(gate_hs), .gate_ls(gate_ls), .fault(fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural expectation model
  logic [2:0] m_h1, m_h2, m_l1, m_l2;
  bit         m_r1, m_r2, m_e1, m_e2;
  bit  [2:0]  m_hs, m_ls, m_pre, m_run, m_flt;
  int         m_cnt [3];

  task automatic clear_legs();
    m_e1 = 0; m_e2 = 0;
    m_hs = '0; m_ls = '0; m_pre = '0; m_run = '0;
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
  endtask

  task automatic model_reset();
    clear_legs();
    m_h1 = 3'b111; m_h2 = 3'b111; m_l1 = '0; m_l2 = '0;
    m_r1 = 0; m_r2 = 0; m_flt = '0;
  endtask

  function automatic int sat(int v);
    return (v >= 63) ? 63 : v + 1;
  endfunction

  task automatic leg_edge(int i, bit hr, bit lr);
    bit wh = hr && !lr;
    bit wl = lr && !hr;
    bit ok = cfg_dt_bypass || (m_cnt[i] >= int'(cfg_dead));
    bit hs0 = m_hs[i], ls0 = m_ls[i], pre0 = m_pre[i];
    m_pre[i] = pre0 | (ls0 & m_run[i]);
    m_run[i] = ls0;
    if (cfg_xc_bypass) begin
      m_hs[i] = hr & pre0;
      m_ls[i] = lr;
      m_cnt[i] = (m_hs[i] | m_ls[i]) ? 0 : sat(m_cnt[i]);
    end else if ((hs0 && ls0) || (hs0 && !wh) || (ls0 && !wl)) begin
      m_hs[i] = 0; m_ls[i] = 0; m_cnt[i] = 0;
    end else if (hs0 || ls0) begin
    end else if (ok && wl) begin
      m_ls[i] = 1;
    end else if (ok && wh && pre0) begin
      m_hs[i] = 1;
    end else begin
      m_cnt[i] = sat(m_cnt[i]);
    end
  endtask

  task automatic model_edge();
    logic [2:0] h2o = m_h2, l2o = m_l2;
    bit r2o = m_r2, e2o = m_e2;
    if (!rst_n) return;
    if (r2o && e2o)
      for (int i = 0; i < 3; i++) leg_edge(i, !h2o[i], l2o[i]);
    if (r2o)
      for (int i = 0; i < 3; i++)
        if (e2o && !h2o[i] && l2o[i] && !cfg_xc_bypass) m_flt[i] = 1;
    if (r2o) begin
      m_h2 = m_h1; m_h1 = hs_cmd_n; m_l2 = m_l1; m_l1 = ls_cmd;
    end
    if (r2o && en_a && en_b) begin
      m_e2 = m_e1; m_e1 = 1;
    end
    m_r2 = m_r1; m_r1 = 1;
  endtask

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_model();
    bit p = en_a && en_b && rst_n;
    chk("R4 gate_hs vs model", gate_hs, m_hs & {3{p}});
    chk("R4 gate_ls vs model", gate_ls, m_ls & {3{p}});
    chk("R5 fault vs model", fault, m_flt);
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk_model();
    end
  endtask

  task automatic set_en(bit a, bit b);
    en_a = a; en_b = b;
    if (!(a && b)) clear_legs();
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9157));
    en_a = 0; en_b = 0; hs_cmd_n = 3'b111; ls_cmd = '0;
    cfg_dead = 6'd2; cfg_dt_bypass = 0; cfg_xc_bypass = 0;
    do_reset();
    chk("R2 gate_hs in reset", gate_hs, '0);
    chk("R2 fault in reset", fault, '0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    step(4);
    set_en(1, 1);
    step(4);
    // R3 idle commands keep outputs off
    chk("R3 idle gate_hs", gate_hs, '0);
    chk("R3 idle gate_ls", gate_ls, '0);
    // R9 high side blocked before any low-side pulse
    hs_cmd_n = 3'b110;
    step(8);
    chk("R9 hs blocked before precharge", gate_hs, '0);
    // R4 latency of low-side turn-on
    hs_cmd_n = 3'b111; ls_cmd = 3'b001;
    step(2);
    chk("R4 ls not yet on after 2 edges", gate_ls, '0);
    step(1);
    chk("R4 ls on after 3 edges", gate_ls, 3'b001);
    step(3);
    // R7 changeover with dead=2
    ls_cmd = '0; hs_cmd_n = 3'b110;
    step(3);
    chk("R7 ls off at edge 3", gate_ls, '0);
    step(2);
    chk("R7 hs still blanked at edge 5", gate_hs, '0);
    step(1);
    chk("R7 hs on at edge 6", gate_hs, 3'b001);
    // R8 dead-time bypass
    cfg_dt_bypass = 1;
    hs_cmd_n = 3'b111; ls_cmd = 3'b001;
    step(3);
    chk("R8 leg off at edge 3", gate_hs | gate_ls, '0);
    step(1);
    chk("R8 ls on at edge 4", gate_ls, 3'b001);
    cfg_dt_bypass = 0;
    // R5 conflicting commands on phase 1
    ls_cmd = 3'b010; hs_cmd_n = 3'b101;
    step(3);
    chk("R5 phase 1 held off", (gate_hs | gate_ls) & 3'b010, '0);
    chk("R5 fault on phase 1", fault, 3'b010);
    hs_cmd_n = 3'b111; ls_cmd = 3'b100;
    step(6);
    chk("R3 ls phase 2 on", gate_ls, 3'b100);
    // R1 asynchronous force-off
    set_en(1, 0);
    #1;
    chk("R1 outputs off with en_b low", gate_ls | gate_hs, '0);
    chk("R11 fault kept through disable", fault, 3'b010);
    @(negedge clk);
    step(3);
    set_en(1, 1);
    ls_cmd = '0; hs_cmd_n = 3'b011;
    step(10);
    chk("R10 precharge lost after disable", gate_hs, '0);
    // R6 cross-conduction override
    cfg_xc_bypass = 1;
    ls_cmd = 3'b100;
    step(8);
    chk("R6 both on hs", gate_hs & 3'b100, 3'b100);
    chk("R6 both on ls", gate_ls & 3'b100, 3'b100);
    chk("R6 no new fault", fault, 3'b010);
    cfg_xc_bypass = 0;
    hs_cmd_n = 3'b111; ls_cmd = '0;
    step(5);
    do_reset();
    chk("R2 fault cleared by reset", fault, '0);
    chk("R2 outputs off in reset", gate_hs | gate_ls, '0);
    @(negedge clk);
    rst_n = 1;
    step(3);
    set_en(1, 1);
    // constrained random phase
    for (int c = 0; c < 6000; c++) begin
      int r = int'($urandom_range(0, 999));
      if (r < 120) hs_cmd_n[$urandom_range(0, 2)] ^= 1'b1;
      else if (r < 260) ls_cmd[$urandom_range(0, 2)] ^= 1'b1;
      else if (r < 266) set_en(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      else if (r < 290) set_en(1, 1);
      else if (r < 296) cfg_dead = 6'($urandom_range(0, 6));
      else if (r < 299) cfg_dt_bypass = ~cfg_dt_bypass;
      else if (r < 301) cfg_xc_bypass = ~cfg_xc_bypass;
      else if (r == 302 && c > 100) begin
        do_reset();
        @(negedge clk);
        rst_n = 1;
      end
      step(1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule